// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words. The write side and the read side each have their own clock. The two clocks may be one shared net, or they may run with no fixed relation to each other. A word enters on a write-clock edge when both write qualifiers are active. A word leaves into a registered output on a read-clock edge when both read enables are active. The output pins float whenever the output enable is inactive.

Four flags, all active low, report the fill state: Empty, Full, Almost-Empty and Almost-Full. The two "almost" thresholds are held in four byte-wide offset registers, and their defaults are seven words. The pointers cross between the clock domains as Gray code through two-stage synchronizers. Empty and Almost-Empty are derived on the read side. Full and Almost-Full are derived on the write side.

The second write qualifier pin has two possible roles, and reset selects which one it takes. If the pin is held low during reset, it becomes an active-low offset-access strobe. While the strobe is active, writes load the offset registers from the data inputs and reads place them on the data outputs.

Top module: `fifo9_pflag`

## Requirements
- R1: While and after reset, empty_n and aempty_n are 0 and full_n and afull_n are 1. dout reads 0. Both offsets return to the default of 7, and both offset-access indices return to the first slot.
- R2: A word is stored on a wclk edge when wen1_n=0, we2_ld=1 and Full is inactive. A word is moved to dout on an rclk edge when ren1_n=0, ren2_n=0 and Empty is inactive (and no offset read is taking place). Words come out in the order they were written.
- R3: With no reads, full_n goes to 0 after exactly DEPTH accepted writes. While full_n=0, writes are ignored and the stored contents are not changed.
- R4: While empty_n=0, a read request leaves dout unchanged.
- R5: With default offsets, aempty_n=0 when the fill level is 7 or less, and afull_n=0 when the fill level is DEPTH-7 or more.
- R6: If we2_ld is 0 during reset, the block is in offset mode. In offset mode, a wclk edge with wen1_n=0 and we2_ld=0 writes din[7:0] into the offset slot chosen by a 2-bit write index, then advances that index. The slot order is: empty-offset low byte (0), empty-offset high byte (1), full-offset low byte (2), full-offset high byte (3). The index wraps from 3 back to 0.
- R7: In offset mode, an rclk edge with we2_ld=0 and both read enables at 0 places {1'b0, slot byte} on dout and advances a separate 2-bit read index in the same slot order. The FIFO contents and the Empty flag are not changed.
- R8: With programmed offsets AE and AF, aempty_n=0 exactly when the level is at most AE, and afull_n=0 exactly when the level is at least DEPTH-AF.
- R9: While oe_n=1, every bit of dout is high impedance.
- R10: If we2_ld is 1 during reset (standard mode), we2_ld=0 blocks writes even when wen1_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Reset, active low |
| wen1_n | input | 1 | First write enable, active low |
| we2_ld | input | 1 | Second write enable (active high), or offset-access strobe (active low) when selected at reset |
| din | input | DW | Write data; the low 8 bits load offsets |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DW | Registered read data, three-state |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-Full flag, active low |

## Verification
The bench builds the block with DEPTH=64 and keeps the default offsets of 7. With that depth, filling to capacity and then overrunning it costs only a few dozen cycles. The Full boundary and both default almost-flag thresholds can therefore be crossed in both directions many times within one run. The bench then resets into offset mode with small programmed offsets (3 and 10), which moves both thresholds well away from the defaults. This shows that the flags follow the loaded offset registers rather than fixed values.

// File: rtl/fifo9_pflag.sv
module fifo9_pflag #(
  parameter int DEPTH  = 256,
  parameter int DW     = 9,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          we2_ld,
  input  logic [DW-1:0] din,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [15:0] AE_W = 16'(AE_DEF);
  localparam logic [15:0] AF_W = 16'(AF_DEF);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          ld_mode;
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   wg1, wg2, rg1, rg2;
  logic [AW:0]   wlvl, rlvl;
  logic [7:0]    ofs [4];
  logic [1:0]    widx, ridx;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  wire ld_act = ld_mode & ~we2_ld;
  wire wr_go  = ~wen1_n & we2_ld & full_n;
  wire ld_wr  = ~wen1_n & ld_act;
  wire rd_en  = ~ren1_n & ~ren2_n;
  wire ld_rd  = rd_en & ld_act;
  wire rd_go  = rd_en & ~ld_act & empty_n;

  wire [AW:0] wbin_nx = wbin + {{AW{1'b0}}, wr_go};
  wire [AW:0] rbin_nx = rbin + {{AW{1'b0}}, rd_go};

  always_ff @(posedge wclk)
    if (!rst_n) ld_mode <= ~we2_ld;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rg1    <= '0;
      rg2    <= '0;
      widx   <= '0;
      ofs[0] <= AE_W[7:0];
      ofs[1] <= AE_W[15:8];
      ofs[2] <= AF_W[7:0];
      ofs[3] <= AF_W[15:8];
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rg1   <= rgray;
      rg2   <= rg1;
      if (ld_wr) begin
        ofs[widx] <= din[7:0];
        widx      <= widx + 2'd1;
      end
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg1   <= '0;
      wg2   <= '0;
      ridx  <= '0;
      q     <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wg1   <= wgray;
      wg2   <= wg1;
      if (rd_go) q <= mem[rbin[AW-1:0]];
      else if (ld_rd) begin
        q    <= {{(DW-8){1'b0}}, ofs[ridx]};
        ridx <= ridx + 2'd1;
      end
    end

  assign wlvl     = wbin - g2b(rg2);
  assign rlvl     = g2b(wg2) - rbin;
  assign full_n   = (wlvl != (AW+1)'(DEPTH));
  assign afull_n  = (32'(wlvl) + 32'({ofs[3], ofs[2]})) < 32'(DEPTH);
  assign empty_n  = (rlvl != '0);
  assign aempty_n = 32'(rlvl) > 32'({ofs[1], ofs[0]});
  assign dout     = oe_n ? {DW{1'bz}} : q;

  assert_hold_full_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  assert_level_bound_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    wlvl <= (AW+1)'(DEPTH));
  assert_hold_empty_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));
  assert_full_in_af_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  assert_empty_in_ae_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  assert_wgray_step_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  assert_rgray_step_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));

endmodule

// File: tb/fifo9_pflag_bench.sv
module fifo9_pflag_bench;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen1_n = 1'b1, we2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [8:0] din = '0;
  wire  [8:0] dout;
  wire empty_n, aempty_n, full_n, afull_n;

  always #5 clk = ~clk;

  fifo9_pflag #(.DEPTH(DEPTH)) u_fifo9_pflag (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .we2_ld(we2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit mode;
  logic [8:0] mq[$];
  logic [7:0] mofs[4];
  logic [1:0] mwi, mri;
  logic [8:0] last;

  function automatic int ae_val();  return {mofs[1], mofs[0]}; endfunction
  function automatic int af_val();  return {mofs[3], mofs[2]}; endfunction
  function automatic bit exp_ae_n(int lvl); return !(lvl <= ae_val()); endfunction
  function automatic bit exp_af_n(int lvl); return !(lvl >= DEPTH - af_val()); endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit ldm);
    rst_n = 1'b0; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    we2_ld = ~ldm;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; we2_ld = 1'b1;
    @(negedge clk);
    mode = ldm; mq.delete(); mwi = 0; mri = 0; last = '0;
    mofs[0] = 8'd7; mofs[1] = 8'd0; mofs[2] = 8'd7; mofs[3] = 8'd0;
  endtask

  task automatic wcyc(bit w1n, bit w2, logic [8:0] d);
    wen1_n = w1n; we2_ld = w2; din = d;
    @(negedge clk);
    wen1_n = 1'b1; we2_ld = 1'b1;
    if (!w1n && w2 && mq.size() < DEPTH) mq.push_back(d);
    else if (!w1n && !w2 && mode) begin mofs[mwi] = d[7:0]; mwi++; end
  endtask

  task automatic rcyc(bit r1n, bit r2n, bit ldlow, string tag);
    logic [8:0] e;
    ren1_n = r1n; ren2_n = r2n; we2_ld = ~ldlow;
    @(negedge clk);
    ren1_n = 1'b1; ren2_n = 1'b1; we2_ld = 1'b1;
    e = last;
    if (!r1n && !r2n) begin
      if (mode && ldlow) begin e = {1'b0, mofs[mri]}; mri++; end
      else if (mq.size() > 0) e = mq.pop_front();
    end
    chk(tag, int'(dout), int'(e));
    last = e;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic flags(string tag);
    int lvl;
    lvl = mq.size();
    chk({tag, " empty_n"}, empty_n, lvl != 0);
    chk({tag, " aempty_n"}, aempty_n, exp_ae_n(lvl));
    chk({tag, " full_n"}, full_n, lvl != DEPTH);
    chk({tag, " afull_n"}, afull_n, exp_af_n(lvl));
  endtask

  task automatic fill_to(int lvl);
    while (mq.size() < lvl) wcyc(1'b0, 1'b1, 9'($urandom));
    settle();
  endtask

  task automatic drain();
    while (mq.size() > 0) rcyc(1'b0, 1'b0, 1'b0, "R2 drain");
    settle();
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 empty_n in reset", empty_n, 0);
    chk("R1 full_n in reset", full_n, 1);
    do_reset(1'b0);
    flags("R1");
    chk("R1 dout", int'(dout), 0);

    oe_n = 1'b1; #1;
    chk("R9 dout floats", int'(dout === 9'bzzzzzzzzz), 1);
    oe_n = 1'b0; #1;
    chk("R9 dout driven", int'(dout === 9'bzzzzzzzzz), 0);

    repeat (3) wcyc(1'b0, 1'b0, 9'h1A5);
    settle();
    flags("R10 blocked write");
    rcyc(1'b0, 1'b0, 1'b0, "R4 read while empty");

    for (int lvl = 1; lvl <= 8; lvl++) begin
      wcyc(1'b0, 1'b1, 9'(lvl * 37));
      settle();
      flags("R5 low edge");
    end
    drain();

    for (int round = 0; round < 30; round++) begin
      int n;
      n = $urandom_range(0, 40);
      for (int i = 0; i < n; i++)
        wcyc(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) != 0), 9'($urandom));
      settle();
      flags("R5 random");
      n = $urandom_range(0, 40);
      for (int i = 0; i < n; i++)
        rcyc(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0), 1'b0, "R2 random");
      settle();
      flags("R5 random");
    end
    drain();
    rcyc(1'b0, 1'b0, 1'b0, "R4 held after drain");

    fill_to(DEPTH - 8);
    flags("R5 high edge");
    fill_to(DEPTH - 7);
    flags("R5 high edge");
    fill_to(DEPTH - 1);
    flags("R3 one short");
    fill_to(DEPTH);
    flags("R3 full");
    repeat (4) wcyc(1'b0, 1'b1, 9'h0FF);
    settle();
    flags("R3 overrun");
    drain();
    flags("R3 after drain");

    do_reset(1'b1);
    flags("R1 offset mode");
    for (int i = 0; i < 4; i++) rcyc(1'b0, 1'b0, 1'b1, "R7 default readback");
    wcyc(1'b0, 1'b0, 9'd5);
    wcyc(1'b0, 1'b0, 9'd0);
    wcyc(1'b0, 1'b0, 9'd10);
    wcyc(1'b0, 1'b0, 9'd0);
    for (int i = 0; i < 4; i++) rcyc(1'b0, 1'b0, 1'b1, "R7 readback");
    wcyc(1'b0, 1'b0, 9'd3);
    for (int i = 0; i < 4; i++) rcyc(1'b0, 1'b0, 1'b1, "R6 wrap readback");
    chk("R6 ae offset", ae_val(), 3);
    for (int lvl = 1; lvl <= 5; lvl++) begin
      fill_to(lvl);
      flags("R8 ae");
    end
    rcyc(1'b0, 1'b0, 1'b1, "R7 readback with data");
    settle();
    flags("R7 fifo untouched");
    rcyc(1'b0, 1'b0, 1'b0, "R7 first word intact");
    fill_to(DEPTH - 11);
    flags("R8 af");
    fill_to(DEPTH - 10);
    flags("R8 af");
    fill_to(DEPTH);
    flags("R8 full");
    drain();
    flags("R8 empty");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule